// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block is a PHY management controller that sits behind a simple register port. Software composes a complete clause-22 management frame as one 32-bit command word: start code, opcode, PHY address, register address, turnaround code and 16 data bits. It writes the word to the command register, and the engine puts 32 preamble ones on the management data line and then the 32 command bits, most significant first. The management clock is derived from the system clock by a fixed divider.

For a read, the engine releases the data line from the second turnaround bit to the end of the frame. It samples the 16 bits the PHY returns on rising clock edges and writes them into the low half of the command register when the frame ends. Software learns that a frame has finished by polling an idle flag in the status register. The port accepts commands only while its enable bit in the control register is set.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset the idle flag reads 1, the control and command registers read 0, `mdc` is 0 and `mdio_oe` is 0.
- R2: A frame lasts 64 bit periods: 32 ones, then command bits 31 down to 0 in that order. Command layout: start [31:30] (01), opcode [29:28], PHY address [27:23], register address [22:18], turnaround [17:16] (10), data [15:0].
- R3: `mdc` has a period of `MDC_DIV` (default 48) system clocks. It is low for the first half of each bit period and high for the second half. `mdio_o` changes only together with a falling edge of `mdc`, or while `mdc` is low.
- R4: Status register (address 1) bit 2 is the idle flag. It goes to 0 on the cycle after a command is accepted and returns to 1 exactly 64 × `MDC_DIV` cycles later. While the engine is idle, `mdc` stays low.
- R5: With opcode 10 (read), `mdio_oe` is 0 from frame bit 47 (the second turnaround bit) through bit 63.
- R6: With any other opcode (01 is a write), `mdio_oe` is 1 for all 64 bits, so the engine drives the 10 turnaround itself.
- R7: During a read, `mdio_i` is sampled at each `mdc` rising edge of frame bits 48 to 63, most significant bit first. At the end of the frame the 16 sampled bits replace command bits [15:0], and bits [31:16] keep their values.
- R8: Control register (address 0) bit 4 enables the port. A command write while this bit is 0 is ignored: no frame starts and the command register keeps its value.
- R9: A command write while a frame is in progress is ignored. The running frame and the command register contents are unaffected.
- R10: Register reads are combinational. Address 0 returns only bit 4 (all other bits read 0), address 1 returns only bit 2, address 2 returns the command register, and address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 command |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Management data line, input side |
| mdio_o | output | 1 | Management data line, output value |
| mdio_oe | output | 1 | Management data line output enable |

## Verification
An accepted command write changes the idle flag on the very next cycle. Every later output depends only on the number of cycles since the accepting edge: bit period k = t / `MDC_DIV`, and `mdc` is high when t mod `MDC_DIV` is at least half the divider. The read data appears in the command register on the cycle after the edge that ends bit period 63. The bench keeps that cycle count in a behavioural model advanced on each falling system-clock edge, and it compares `mdc`, `mdio_oe`, `mdio_o` (while driven) and the addressed register against the model on every clock. Its PHY stand-in changes `mdio_i` only at falling system-clock edges, so the value is stable at the edge where the engine samples it.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    localparam int CMD_W          = 32;
    localparam int DATA_W         = 16;
    localparam int PRE_LEN        = 32;
    localparam int FRAME_LEN      = PRE_LEN + CMD_W;
    localparam int IDX_W          = $clog2(FRAME_LEN);
    localparam int CMD_SEL_W      = $clog2(CMD_W);
    localparam int OP_HI          = 29;
    localparam int RD_RELEASE_IDX = PRE_LEN + CMD_W - 1 - DATA_W;
    localparam int RD_DATA_IDX    = FRAME_LEN - DATA_W;
    localparam int ADDR_W         = 2;
    localparam int CTRL_EN_BIT    = 4;
    localparam int STAT_IDLE_BIT  = 2;

    localparam logic [1:0]        OP_READ   = 2'b10;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CMD  = 2'd2;

    typedef struct packed {
        logic              en;
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] cap;
    } eng_state_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW   = $clog2(DIV);
    localparam int HALF = DIV / 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_state_t;

    div_state_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (!run || div_q.cnt == CW'(DIV - 1)) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
        div_d.mdc = (div_d.cnt >= CW'(HALF));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign mdc       = div_q.mdc;
    assign rise_tick = run && (div_q.cnt == CW'(HALF - 1));
    assign fall_tick = run && (div_q.cnt == CW'(DIV - 1));

    // R3
    mdc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |=> mdc);
    // R3
    mdc_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_tick |=> !mdc);
endmodule

// File: rtl/mdio_pin_drive.sv
module mdio_pin_drive
    import mdio_mgmt_pkg::*;
(
    input  logic             busy,
    input  logic [IDX_W-1:0] idx,
    input  logic [CMD_W-1:0] cmd,
    output logic             rd_frame,
    output logic             mdio_o,
    output logic             mdio_oe
);
    logic [CMD_SEL_W-1:0] sel;

    always_comb begin
        rd_frame = (cmd[OP_HI -: 2] == OP_READ);
        sel      = CMD_SEL_W'(CMD_W - 1) - idx[CMD_SEL_W-1:0];
        if (!busy || idx < IDX_W'(PRE_LEN)) begin
            mdio_o = 1'b1;
        end else begin
            mdio_o = cmd[sel];
        end
        mdio_oe = busy && !(rd_frame && idx >= IDX_W'(RD_RELEASE_IDX));
    end
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
    import mdio_mgmt_pkg::*;
#(
    parameter int MDC_DIV = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CMD_W-1:0]  reg_wdata,
    output logic [CMD_W-1:0]  reg_rdata,
    output logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe
);
    eng_state_t st_d, st_q;
    logic rise_tick, fall_tick, rd_frame;
    logic cmd_wr, ctrl_wr, last_bit;

    mdio_clk_div #(.DIV(MDC_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (st_q.busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_pin_drive u_pin (
        .busy     (st_q.busy),
        .idx      (st_q.idx),
        .cmd      (st_q.cmd),
        .rd_frame (rd_frame),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    assign cmd_wr   = reg_wr && (reg_addr == ADDR_CMD);
    assign ctrl_wr  = reg_wr && (reg_addr == ADDR_CTRL);
    assign last_bit = fall_tick && (st_q.idx == IDX_W'(FRAME_LEN - 1));

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.en = reg_wdata[CTRL_EN_BIT];
        end
        if (!st_q.busy) begin
            if (cmd_wr && st_q.en) begin
                st_d.cmd  = reg_wdata;
                st_d.busy = 1'b1;
                st_d.idx  = '0;
                st_d.cap  = '0;
            end
        end else begin
            if (rise_tick && rd_frame && st_q.idx >= IDX_W'(RD_DATA_IDX)) begin
                st_d.cap = {st_q.cap[DATA_W-2:0], mdio_i};
            end
            if (fall_tick) begin
                st_d.idx = st_q.idx + 1'b1;
                if (last_bit) begin
                    st_d.busy = 1'b0;
                    if (rd_frame) begin
                        st_d.cmd[DATA_W-1:0] = st_d.cap;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: reg_rdata[CTRL_EN_BIT]   = st_q.en;
            ADDR_STAT: reg_rdata[STAT_IDLE_BIT] = !st_q.busy;
            ADDR_CMD:  reg_rdata                = st_q.cmd;
            default:   reg_rdata                = '0;
        endcase
    end

    // R4
    idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> !mdc);
    // R4
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> $past(cmd_wr));
    // R5
    drive_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> st_q.busy);
    // R3
    data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !$stable(mdio_o)) |-> !mdc);
    // R8
    disabled_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && !st_q.busy) |=> !st_q.busy);
    // R9
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && cmd_wr && !last_bit) |=> $stable(st_q.cmd));
endmodule

// File: tb/sim_mdio_mgmt_engine.sv
module sim_mdio_mgmt_engine;
    localparam int DIV   = 48;
    localparam int HALF  = DIV / 2;
    localparam int FLEN  = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd1;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_i, mdio_o, mdio_oe;

    int n_vec = 0;
    int n_bad = 0;

    // behavioural reference state
    logic        en_m = 1'b0;
    logic        busy_m = 1'b0;
    int          t_m = 0;
    logic [31:0] cmd_m = '0;
    logic [15:0] cap_m = '0;
    logic [15:0] reply = 16'hA5C3;

    always #10 clk = ~clk;

    initial mdio_i = 1'b1;

    mdio_mgmt_engine #(.MDC_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    function automatic logic rd_op(input logic [31:0] c);
        return c[29:28] == 2'b10;
    endfunction

    // reference model and per-cycle comparison, on falling system edges
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                en_m = 1'b0; busy_m = 1'b0; t_m = 0; cmd_m = '0; cap_m = '0;
            end else begin
                if (busy_m) begin
                    if ((t_m % DIV) == HALF - 1 && rd_op(cmd_m) && (t_m / DIV) >= 48)
                        cap_m = {cap_m[14:0], mdio_i};
                    if (t_m == FLEN * DIV - 1) begin
                        busy_m = 1'b0;
                        if (rd_op(cmd_m)) cmd_m[15:0] = cap_m;
                    end else begin
                        t_m++;
                    end
                end else if (reg_wr && reg_addr == 2'd2 && en_m) begin
                    cmd_m = reg_wdata; busy_m = 1'b1; t_m = 0; cap_m = '0;
                end
                if (reg_wr && reg_addr == 2'd0) en_m = reg_wdata[4];
            end
            begin
                int k;
                int ph;
                logic mdc_e, oe_e, o_e;
                logic [31:0] rd_e;
                k = t_m / DIV;
                ph = t_m % DIV;
                mdc_e = busy_m && ph >= HALF;
                oe_e = busy_m && !(rd_op(cmd_m) && k >= 47);
                o_e = (!busy_m || k < 32) ? 1'b1 : cmd_m[63 - k];
                case (reg_addr)
                    2'd0: rd_e = {27'd0, en_m, 4'd0};
                    2'd1: rd_e = {29'd0, !busy_m, 2'd0};
                    2'd2: rd_e = cmd_m;
                    default: rd_e = '0;
                endcase
                if (!rst_n) begin
                    chk("R1 mdc", {31'd0, mdc}, 32'd0);
                    chk("R1 mdio_oe", {31'd0, mdio_oe}, 32'd0);
                    chk("R1 reg_rdata", reg_rdata, rd_e);
                end else begin
                    chk("R3 mdc", {31'd0, mdc}, {31'd0, mdc_e});
                    chk(rd_op(cmd_m) ? "R5 mdio_oe" : "R6 mdio_oe",
                        {31'd0, mdio_oe}, {31'd0, oe_e});
                    if (oe_e) chk("R2 mdio_o", {31'd0, mdio_o}, {31'd0, o_e});
                    case (reg_addr)
                        2'd0: chk("R10 ctrl read", reg_rdata, rd_e);
                        2'd1: chk("R4 idle flag", reg_rdata, rd_e);
                        2'd2: chk("R7 cmd read", reg_rdata, rd_e);
                        default: chk("R10 unused read", reg_rdata, rd_e);
                    endcase
                end
                if (busy_m && rd_op(cmd_m) && k >= 48) mdio_i = reply[63 - k];
                else mdio_i = 1'b1;
            end
        end
    end

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); #1;
        reg_wr = 1'b0; reg_addr = 2'd1;
    endtask

    task automatic peek(input logic [1:0] a, input string tag, input logic [31:0] exp);
        @(negedge clk); #1;
        reg_addr = a;
        @(negedge clk); #2;
        chk(tag, reg_rdata, exp);
        reg_addr = 2'd1;
    endtask

    task automatic wait_idle();
        while (busy_m) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa,
                                       input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, op, pa, ra, 2'b10, d};
    endfunction

    initial begin
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b1;
        peek(2'd1, "R1 idle after reset", 32'h4);
        peek(2'd2, "R1 cmd after reset", 32'h0);
        peek(2'd0, "R1 ctrl after reset", 32'h0);
        // R8: command write while disabled is ignored
        wr_reg(2'd2, mk(2'b01, 5'h03, 5'h00, 16'h1111));
        repeat (10) @(negedge clk);
        peek(2'd2, "R8 cmd unchanged while disabled", 32'h0);
        peek(2'd1, "R8 still idle while disabled", 32'h4);
        // R10: only bit 4 of control is kept
        wr_reg(2'd0, 32'hFFFF_FFFF);
        peek(2'd0, "R10 ctrl readback", 32'h10);
        peek(2'd3, "R10 unused address", 32'h0);
        // R6/R2: write frame, then R9: write while busy
        wr_reg(2'd2, mk(2'b01, 5'h13, 5'h04, 16'hBEEF));
        peek(2'd1, "R4 busy after accept", 32'h0);
        repeat (100) @(negedge clk);
        wr_reg(2'd2, mk(2'b10, 5'h1F, 5'h1F, 16'h0000));
        wait_idle();
        peek(2'd2, "R9 cmd kept from first write", mk(2'b01, 5'h13, 5'h04, 16'hBEEF));
        // R5/R7: read frame
        wr_reg(2'd2, mk(2'b10, 5'h01, 5'h1F, 16'h1234));
        wait_idle();
        peek(2'd2, "R7 read data returned", mk(2'b10, 5'h01, 5'h1F, 16'hA5C3));
        // R7: second read with another reply pattern
        reply = 16'h0F81;
        wr_reg(2'd2, mk(2'b10, 5'h1A, 5'h02, 16'hFFFF));
        wait_idle();
        peek(2'd2, "R7 second read data", mk(2'b10, 5'h1A, 5'h02, 16'h0F81));
        // R8: disable, then a command is ignored again
        wr_reg(2'd0, 32'h0);
        wr_reg(2'd2, mk(2'b01, 5'h05, 5'h05, 16'h5555));
        repeat (10) @(negedge clk);
        peek(2'd2, "R8 ignored after disable", mk(2'b10, 5'h1A, 5'h02, 16'h0F81));
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule